// File: doc/BRIEF.md
# Pattern-Unlocked Serial Clock Register Port

This block sits on the chip-enable, output-enable and write-enable strobes of a memory bus and watches the bus cycles meant for that memory. It uses no address of its own. Software opens access with one read cycle. It then issues 64 write cycles that carry a fixed key on the single data-in line, one bit per cycle. The key is the bytes C5, 3A, A3, 5C, C5, 3A, A3, 5C, and each byte is sent least-significant bit first. A wrong bit stops recognition. After that, writes are ignored until the next read cycle restarts it.

Once the whole key matches, the next 64 bus cycles move the clock core's eight 8-bit registers, one bit per cycle. Read cycles place bits on the data-out line. Write cycles collect bits from data-in. The transfer always runs from bit 0 of register 0 up to bit 7 of register 7. The block captures a snapshot of the clock core's registers at the moment of unlock, so a read transfer is coherent. On a write transfer, each byte whose eight cycles were all writes is handed to the clock core as a whole byte.

During the transfer the memory's chip-enable is held inactive. At all other times it follows the bus chip-enable. The block detects bus cycles as synchronized falling edges of the strobes in its own clock domain. An external abort input, which the clock core can mask, returns the block to the locked state.

Top module: `phantom_port`

## Requirements
- R1: After reset the block is locked: `ce_out_n` equals `ce_in_n`, `q_oe` is low and `wr_stb` is low.
- R2: Write cycles issued after reset with no preceding read cycle never unlock the block, even when they carry the full key.
- R3: A read cycle followed by 64 write cycles carrying key bit k = byte[k/8] bit (k%8), with bytes C5,3A,A3,5C,C5,3A,A3,5C, unlocks the block. From the next bus cycle on, `ce_out_n` is held high.
- R4: A write carrying a wrong key bit halts recognition. Later writes are ignored, including a resend of the correct remaining bits, until a read cycle.
- R5: A read cycle during recognition restarts it at key bit 0. A full key sent after that read unlocks the block.
- R6: In a read transfer, the n-th transfer cycle (n = 0..63) drives `q_out` with bit n of `rd_regs` as sampled at unlock. Bit 8r+b is bit b of register r. Changes on `rd_regs` after unlock have no effect.
- R7: In a write transfer, the bit of the n-th transfer cycle lands in register n/8 at bit n%8. Each completed byte raises `wr_stb` for one clock, with `wr_idx` = n/8 and `wr_data` holding the byte.
- R8: After the 64th transfer cycle the block relocks: `ce_out_n` follows `ce_in_n` again and `q_oe` stays low.
- R9: Strobe activity while `ce_in_n` is high does not disturb recognition or transfer.
- R10: With `abort_ignore` low, a low on `abort_n` ends a transfer, and the partially collected byte is not committed. With `abort_ignore` high, `abort_n` has no effect.
- R11: A byte of the transfer in which any cycle was a read is not committed, even if its other cycles were writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_in_n | input | 1 | Bus chip-enable for the memory, active low |
| oe_n | input | 1 | Bus output enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| d_in | input | 1 | Serial data-in bit |
| q_out | output | 1 | Serial data-out bit |
| q_oe | output | 1 | Drive enable for `q_out` |
| ce_out_n | output | 1 | Chip-enable to the memory, active low |
| abort_n | input | 1 | Asynchronous abort request, active low |
| abort_ignore | input | 1 | Masks `abort_n` when high (clock core bit) |
| rd_regs | input | 64 | Clock core registers, register r at bits 8r+7:8r |
| wr_stb | output | 1 | One-clock commit strobe for a completed byte |
| wr_idx | output | 3 | Register index of the committed byte |
| wr_data | output | 8 | Committed byte |

## Verification
The bench builds the block with its default values: eight registers, the 64-bit key and two synchronizer stages. With these values the real entry sequence and a full 64-cycle transfer fit in a few thousand clocks. Bus cycles last several clocks so the synchronizer depth is covered. It also checks these paths: a mismatch followed by the correct remaining bits, a restart by a read halfway through the key, interleaved strobes with the chip-enable idle, and both settings of the abort mask during a partly collected byte.

// File: rtl/phantom_port.sv
module phantom_port #(
  parameter int NUM_REGS    = 8,
  parameter int KEY_LEN     = 64,
  parameter logic [KEY_LEN-1:0] KEY = 64'h5CA33AC5_5CA33AC5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_in_n,
  input  logic                    oe_n,
  input  logic                    we_n,
  input  logic                    d_in,
  output logic                    q_out,
  output logic                    q_oe,
  output logic                    ce_out_n,
  input  logic                    abort_n,
  input  logic                    abort_ignore,
  input  logic [NUM_REGS*8-1:0]   rd_regs,
  output logic                    wr_stb,
  output logic [$clog2(NUM_REGS)-1:0] wr_idx,
  output logic [7:0]              wr_data
);
  localparam int XFER_LEN = NUM_REGS * 8;
  localparam int XP_W     = $clog2(XFER_LEN);
  localparam int KP_W     = $clog2(KEY_LEN);
  localparam logic [4:0] SYNC_RST = 5'b10111;

  typedef enum logic [1:0] {ST_HALT = 2'd0, ST_KEY = 2'd1, ST_XFER = 2'd2} st_t;

  st_t                 st;
  logic [4:0]          sync_q [SYNC_STAGES];
  logic                rd_prev, wr_prev, cyc_own, all_wr;
  logic [KP_W-1:0]     kptr;
  logic [XP_W-1:0]     xptr;
  logic [XFER_LEN-1:0] snap;
  logic [7:0]          byte_sh;
  logic                q_reg;

  wire ce_s    = sync_q[SYNC_STAGES-1][0];
  wire oe_s    = sync_q[SYNC_STAGES-1][1];
  wire we_s    = sync_q[SYNC_STAGES-1][2];
  wire d_s     = sync_q[SYNC_STAGES-1][3];
  wire abort_s = sync_q[SYNC_STAGES-1][4];

  wire rd_act   = ~ce_s & ~oe_s;
  wire wr_act   = ~ce_s & oe_s & ~we_s;
  wire rd_go    = rd_act & ~rd_prev;
  wire wr_go    = wr_act & ~wr_prev;
  wire abort_go = ~abort_s & ~abort_ignore;

  wire       key_hit   = d_s == KEY[kptr];
  wire       last_key  = kptr == KP_W'(KEY_LEN - 1);
  wire       byte_end  = &xptr[2:0];
  wire       last_xfer = xptr == XP_W'(XFER_LEN - 1);
  wire       all_wr_nx = (xptr[2:0] == 3'd0) ? wr_go : (all_wr & wr_go);
  wire [7:0] byte_nx   = wr_go ? {d_s, byte_sh[7:1]} : byte_sh;

  wire blocked = (st == ST_XFER) | cyc_own;
  assign ce_out_n = ce_in_n | blocked;
  assign q_out    = q_reg;
  assign q_oe     = cyc_own & ~ce_in_n & ~oe_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= SYNC_RST;
      rd_prev <= 1'b0;
      wr_prev <= 1'b0;
    end else begin
      sync_q[0] <= {abort_n, d_in, we_n, oe_n, ce_in_n};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      rd_prev <= rd_act;
      wr_prev <= wr_act;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_HALT;
      kptr    <= '0;
      xptr    <= '0;
      snap    <= '0;
      byte_sh <= '0;
      all_wr  <= 1'b0;
      q_reg   <= 1'b0;
      cyc_own <= 1'b0;
      wr_stb  <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (!(rd_act | wr_act)) cyc_own <= 1'b0;
      if (abort_go) begin
        st   <= ST_HALT;
        kptr <= '0;
        xptr <= '0;
      end else begin
        case (st)
          ST_HALT, ST_KEY: begin
            if (rd_go) begin
              st   <= ST_KEY;
              kptr <= '0;
            end else if (wr_go && st == ST_KEY) begin
              if (!key_hit) begin
                st <= ST_HALT;
              end else if (last_key) begin
                st   <= ST_XFER;
                xptr <= '0;
                snap <= rd_regs;
              end else begin
                kptr <= kptr + 1'b1;
              end
            end
          end
          ST_XFER: begin
            if (rd_go | wr_go) begin
              cyc_own <= 1'b1;
              xptr    <= xptr + 1'b1;
              byte_sh <= byte_nx;
              all_wr  <= all_wr_nx;
              if (rd_go) q_reg <= snap[xptr];
              if (byte_end && all_wr_nx) begin
                wr_stb  <= 1'b1;
                wr_idx  <= xptr[XP_W-1:3];
                wr_data <= byte_nx;
              end
              if (last_xfer) st <= ST_HALT;
            end
          end
          default: st <= ST_HALT;
        endcase
      end
    end
  end
endmodule

// File: rtl/phantom_port_chk.sv
module phantom_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_in_n,
  input logic       ce_out_n,
  input logic       q_oe,
  input logic       wr_stb,
  input logic [1:0] st,
  input logic       rd_go,
  input logic       cyc_own
);
  a_r1_follow_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd2 && !cyc_own) |-> (ce_out_n == ce_in_n));

  a_r6_qoe_blocks_memory: assert property (@(posedge clk) disable iff (!rst_n)
    q_oe |-> ce_out_n);

  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r7_strobe_from_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(st) == 2'd2));

  a_r4_halt_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && !rd_go) |=> (st != 2'd2));
endmodule

bind phantom_port phantom_port_chk u_phantom_port_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_in_n  (ce_in_n),
  .ce_out_n (ce_out_n),
  .q_oe     (q_oe),
  .wr_stb   (wr_stb),
  .st       (st),
  .rd_go    (rd_go),
  .cyc_own  (cyc_own)
);

// File: tb/test_phantom_port.sv
`timescale 1ns/1ps
module test_phantom_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_in_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, d_in = 1'b0;
  logic abort_n = 1'b1, abort_ignore = 1'b0;
  logic [63:0] rd_regs = '0;
  logic q_out, q_oe, ce_out_n, wr_stb;
  logic [2:0] wr_idx;
  logic [7:0] wr_data;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic last_ce, last_q, last_qoe;
  logic [10:0] exp_q[$];

  localparam logic [7:0] KEYB [8] = '{8'hC5, 8'h3A, 8'hA3, 8'h5C, 8'hC5, 8'h3A, 8'hA3, 8'h5C};
  localparam logic [63:0] PAT_A = 64'hF0E1_D2C3_B4A5_9687;
  localparam logic [63:0] PAT_W = 64'h1357_9BDF_2468_ACE0;
  localparam logic [63:0] PAT_M = 64'hA5A5_5A5A_3C3C_C3C3;

  always #4 clk = ~clk;

  phantom_port i_phantom_port (
    .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n), .oe_n(oe_n), .we_n(we_n),
    .d_in(d_in), .q_out(q_out), .q_oe(q_oe), .ce_out_n(ce_out_n),
    .abort_n(abort_n), .abort_ignore(abort_ignore), .rd_regs(rd_regs),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  function automatic logic key_bit(int k);
    return KEYB[k/8][k%8];
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(bit is_wr, logic d);
    @(negedge clk);
    ce_in_n = 1'b0;
    if (is_wr) begin we_n = 1'b0; d_in = d; end
    else oe_n = 1'b0;
    @(negedge clk);
    last_ce = ce_out_n;
    repeat (5) @(negedge clk);
    last_q = q_out;
    last_qoe = q_oe;
    ce_in_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic stray();
    @(negedge clk);
    we_n = 1'b0; oe_n = 1'b0; d_in = ~d_in;
    repeat (6) @(negedge clk);
    we_n = 1'b1; oe_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_key(int from, int upto);
    for (int k = from; k < upto; k++) begin
      bus(1'b1, key_bit(k));
      if (k % 16 == 5) stray();
    end
  endtask

  task automatic abort_pulse();
    @(negedge clk); abort_n = 1'b0;
    repeat (4) @(negedge clk); abort_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected commit", {53'd0, wr_idx, wr_data}, 64'h0);
      else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        chk({wr_idx, wr_data} == e, "R7 commit idx/data", {53'd0, wr_idx, wr_data}, {53'd0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(ce_out_n == 1'b1 && q_oe == 1'b0 && wr_stb == 1'b0, "R1 in reset", {ce_out_n, q_oe, wr_stb}, 3'b100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ce_out_n == ce_in_n && !q_oe && !wr_stb, "R1 after reset", {ce_out_n, q_oe, wr_stb}, 3'b100);

    // R2: key without leading read
    send_key(0, 64);
    bus(1'b1, 1'b0);
    chk(last_ce == 1'b0, "R2 no unlock without read", last_ce, 0);

    // R3 / R6 / R9: unlock then read transfer
    rd_regs = PAT_A;
    bus(1'b0, 1'b0);
    chk(last_ce == 1'b0, "R3 read before key reaches memory", last_ce, 0);
    send_key(0, 64);
    rd_regs = ~PAT_A;
    for (int n = 0; n < 64; n++) begin
      bus(1'b0, 1'b0);
      chk(last_ce == 1'b1, "R3 memory blocked in transfer", last_ce, 1);
      chk(last_q == PAT_A[n] && last_qoe, "R6 read bit", {last_qoe, last_q}, {1'b1, PAT_A[n]});
      if (n % 20 == 7) stray();
    end
    bus(1'b1, 1'b0);
    chk(last_ce == 1'b0, "R8 relocked after 64 cycles", last_ce, 0);
    bus(1'b0, 1'b0);
    chk(last_qoe == 1'b0, "R8 no drive after transfer", last_qoe, 0);

    // R7: write transfer
    send_key(0, 64);
    for (int n = 0; n < 64; n++) begin
      if (n % 8 == 7) exp_q.push_back({3'(n / 8), PAT_W[n-7 +: 8]});
      bus(1'b1, PAT_W[n]);
      chk(last_ce == 1'b1, "R7 memory blocked in write transfer", last_ce, 1);
      if (n == 30) stray();
    end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all bytes committed", exp_q.size(), 0);

    // R4: mismatch then correct remainder
    bus(1'b0, 1'b0);
    send_key(0, 10);
    bus(1'b1, ~key_bit(10));
    send_key(10, 64);
    bus(1'b1, 1'b0);
    chk(last_ce == 1'b0, "R4 mismatch stays locked", last_ce, 0);

    // R5 / R11: restart mid-key, then mixed transfer
    bus(1'b0, 1'b0);
    send_key(0, 30);
    bus(1'b0, 1'b0);
    send_key(0, 64);
    for (int n = 0; n < 64; n++) begin
      if (n == 3) bus(1'b0, 1'b0);
      else begin
        if (n % 8 == 7 && n > 7) exp_q.push_back({3'(n / 8), PAT_M[n-7 +: 8]});
        bus(1'b1, PAT_M[n]);
      end
      if (n == 0) chk(last_ce == 1'b1, "R5 unlock after restart", last_ce, 1);
    end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11 mixed byte dropped", exp_q.size(), 0);

    // R10: masked and unmasked abort
    bus(1'b0, 1'b0);
    send_key(0, 64);
    for (int n = 0; n < 10; n++) begin
      if (n == 7) exp_q.push_back({3'd0, PAT_W[7:0]});
      bus(1'b1, PAT_W[n]);
    end
    abort_ignore = 1'b1;
    abort_pulse();
    bus(1'b1, PAT_W[10]);
    chk(last_ce == 1'b1, "R10 masked abort ignored", last_ce, 1);
    abort_ignore = 1'b0;
    abort_pulse();
    bus(1'b1, PAT_W[11]);
    chk(last_ce == 1'b0, "R10 abort relocks", last_ce, 0);
    for (int n = 12; n < 20; n++) bus(1'b1, PAT_W[n]);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R10 partial byte dropped", exp_q.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule